// File: doc/BRIEF.md
# DMA Window Control Register Bank

This block is the software-visible register file of a host-to-PCI bridge. It keeps four address-translation windows, and each window has three 64-bit registers: a window base, a size mask and a translated base. It also keeps one 64-bit bridge control word. The current contents of all of these registers leave the block on flat export ports. An address translator next to the block uses them.

Software reaches the bank through a simple request/response bus. A request carries a byte offset inside a 4 KB region and a byte count, and every legal access moves one full 64-bit word. The register index is the byte offset divided by 64, so each register has a 64-byte slot. The low six offset bits are ignored. A few status and maintenance slots have fixed behaviour. Every slot the bank does not support answers with an error.

Each request gets exactly one response, registered, in the next cycle. The response is a valid pulse, an error bit and the read data. The slot index of every named register is a parameter. The default layout is stated in the requirements.

Top module: `dma_window_regs`

## Requirements
- R1: The register index is reqAddr[11:6]. Bits [5:0] of the offset have no effect on which register an access reaches.
- R2: An access whose reqSize is not 8 (bytes) is answered with rspErr=1 and read data 0, and a write of that kind leaves every register unchanged.
- R3: For window w (0..3), the base register is at index w, the mask register at index 4+w and the translated base at index 8+w. All twelve reset to 0 and return exactly the last value written.
- R4: The control register is at index 12. It resets to 64'h0000_0021_0010_0000 (bit 20 set, bit 32 set, value 2 in bits [39:36]), and all 64 bits are writable.
- R5: The error-status slot (index 15) and the error-mask slot (index 16) read as 0 without error. A write to the error-status slot gets no error and changes no register.
- R6: The cache-invalidate-all slot (index 19) reads as 0 without error. A write to it gets no error and changes no register.
- R7: Every index other than 0–12, 15, 16 and 19 is unsupported. Any read or write to one of them gets rspErr=1, and such a write changes no register.
- R8: A write to the error-mask slot (index 16) gets rspErr=1 and changes no register.
- R9: A request taken at a rising edge produces rspValid=1 for exactly the next cycle, with no response in any other cycle. Whenever rspErr is 1, rspRdata is 0.
- R10: winBaseFlat, winMaskFlat and winXlatFlat carry window w's registers in bits [64w+63:64w], and ctrlWord carries the control register. Each reflects a write from the edge at which the write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 12 | Byte offset inside the 4 KB region |
| reqSize | input | 4 | Access size in bytes |
| reqWdata | input | 64 | Write data |
| rspValid | output | 1 | Response pulse, one cycle after the request |
| rspErr | output | 1 | Access rejected |
| rspRdata | output | 64 | Read data, zero on error and on writes |
| winBaseFlat | output | 256 | Window base registers, window 0 in the low word |
| winMaskFlat | output | 256 | Window mask registers |
| winXlatFlat | output | 256 | Window translated-base registers |
| ctrlWord | output | 64 | Bridge control register |

## Verification
The bench builds the bank with its default parameters: four windows, a 12-bit offset and a 64-byte stride. With this layout the whole index space is only 64 slots, so every slot can be read, written and read again in a complete sweep. The sweep varies the ignored low offset bits, and the bench computes the expected outcome of each slot from the map it holds. Every byte count from 0 to 15 is also driven against a storing register, and a second reset is applied after the writes to bring the reset values within reach once more.

// File: rtl/dwr_pkg.sv
package dwr_pkg;

  // Class of the slot addressed by the current request
  typedef enum logic [2:0] {
    K_BASE = 3'd0,
    K_MASK = 3'd1,
    K_XLAT = 3'd2,
    K_CTRL = 3'd3,
    K_ZERO = 3'd4,
    K_BAD  = 3'd5
  } regKind_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic     fire;
    logic     wrEn;
    regKind_e kind;
  } dwrStrobe_t;

endpackage

// File: rtl/dwr_ctrl.sv
module dwr_ctrl
  import dwr_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int STRIDE_LG   = 6,
  parameter int SIZE_W      = 4,
  parameter int DATA_W      = 64,
  parameter int NUM_WIN     = 4,
  parameter int IDX_BASE0   = 0,
  parameter int IDX_MASK0   = 4,
  parameter int IDX_XLAT0   = 8,
  parameter int IDX_CTRL    = 12,
  parameter int IDX_ERRSTAT = 15,
  parameter int IDX_ERRMASK = 16,
  parameter int IDX_FLUSH   = 19,
  localparam int IDX_W      = ADDR_W - STRIDE_LG,
  localparam int WIN_W      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  output dwrStrobe_t        strobe,
  output logic [WIN_W-1:0]  winSel
);

  localparam int WORD_BYTES = DATA_W / 8;

  logic [IDX_W-1:0] regIdx;
  logic             sizeOk;
  logic             unusedLowBits;
  int               idxI;

  assign regIdx        = reqAddr[ADDR_W-1:STRIDE_LG];
  assign unusedLowBits = ^reqAddr[STRIDE_LG-1:0];
  assign sizeOk        = (reqSize == SIZE_W'(WORD_BYTES));

  always_comb begin
    regKind_e kindNext;
    logic     storing;
    idxI     = int'(regIdx);
    kindNext = K_BAD;
    storing  = 1'b0;
    winSel   = '0;
    if (idxI >= IDX_BASE0 && idxI < IDX_BASE0 + NUM_WIN) begin
      kindNext = K_BASE;
      storing  = 1'b1;
      winSel   = WIN_W'(idxI - IDX_BASE0);
    end else if (idxI >= IDX_MASK0 && idxI < IDX_MASK0 + NUM_WIN) begin
      kindNext = K_MASK;
      storing  = 1'b1;
      winSel   = WIN_W'(idxI - IDX_MASK0);
    end else if (idxI >= IDX_XLAT0 && idxI < IDX_XLAT0 + NUM_WIN) begin
      kindNext = K_XLAT;
      storing  = 1'b1;
      winSel   = WIN_W'(idxI - IDX_XLAT0);
    end else if (idxI == IDX_CTRL) begin
      kindNext = K_CTRL;
      storing  = 1'b1;
    end else if (idxI == IDX_ERRSTAT || idxI == IDX_FLUSH) begin
      kindNext = K_ZERO;
    end else if (idxI == IDX_ERRMASK) begin
      // readable as zero, but a write is rejected
      kindNext = reqWrite ? K_BAD : K_ZERO;
    end
    if (!sizeOk) begin
      kindNext = K_BAD;
    end
    strobe.fire = reqValid;
    strobe.kind = kindNext;
    strobe.wrEn = reqValid && reqWrite && storing && sizeOk;
  end

endmodule

// File: rtl/dwr_datapath.sv
module dwr_datapath
  import dwr_pkg::*;
#(
  parameter int DATA_W           = 64,
  parameter int NUM_WIN          = 4,
  parameter logic [63:0] CTRL_RST = 64'h0000_0021_0010_0000,
  localparam int WIN_W           = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dwrStrobe_t                strobe,
  input  logic [WIN_W-1:0]          winSel,
  input  logic                      reqWrite,
  input  logic [DATA_W-1:0]         reqWdata,
  output logic                      rspValid,
  output logic                      rspErr,
  output logic [DATA_W-1:0]         rspRdata,
  output logic [NUM_WIN*DATA_W-1:0] winBaseFlat,
  output logic [NUM_WIN*DATA_W-1:0] winMaskFlat,
  output logic [NUM_WIN*DATA_W-1:0] winXlatFlat,
  output logic [DATA_W-1:0]         ctrlWord
);

  logic [DATA_W-1:0] baseQ [NUM_WIN];
  logic [DATA_W-1:0] maskQ [NUM_WIN];
  logic [DATA_W-1:0] xlatQ [NUM_WIN];
  logic [DATA_W-1:0] ctrlQ;
  logic [DATA_W-1:0] rdNext;

  genvar w;
  generate
    for (w = 0; w < NUM_WIN; w++) begin : g_win
      logic hitW;
      assign hitW = strobe.wrEn && (winSel == WIN_W'(w));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          baseQ[w] <= '0;
          maskQ[w] <= '0;
          xlatQ[w] <= '0;
        end else if (hitW) begin
          if (strobe.kind == K_BASE) baseQ[w] <= reqWdata;
          if (strobe.kind == K_MASK) maskQ[w] <= reqWdata;
          if (strobe.kind == K_XLAT) xlatQ[w] <= reqWdata;
        end
      end

      assign winBaseFlat[w*DATA_W +: DATA_W] = baseQ[w];
      assign winMaskFlat[w*DATA_W +: DATA_W] = maskQ[w];
      assign winXlatFlat[w*DATA_W +: DATA_W] = xlatQ[w];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= DATA_W'(CTRL_RST);
    end else if (strobe.wrEn && strobe.kind == K_CTRL) begin
      ctrlQ <= reqWdata;
    end
  end

  assign ctrlWord = ctrlQ;

  always_comb begin
    rdNext = '0;
    if (!reqWrite) begin
      unique case (strobe.kind)
        K_BASE:  rdNext = baseQ[winSel];
        K_MASK:  rdNext = maskQ[winSel];
        K_XLAT:  rdNext = xlatQ[winSel];
        K_CTRL:  rdNext = ctrlQ;
        default: rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobe.fire;
      rspErr   <= strobe.fire && (strobe.kind == K_BAD);
      rspRdata <= (strobe.fire && strobe.kind != K_BAD) ? rdNext : '0;
    end
  end

endmodule

// File: rtl/dma_window_regs.sv
module dma_window_regs
  import dwr_pkg::*;
#(
  parameter int ADDR_W            = 12,
  parameter int STRIDE_LG         = 6,
  parameter int SIZE_W            = 4,
  parameter int DATA_W            = 64,
  parameter int NUM_WIN           = 4,
  parameter int IDX_BASE0         = 0,
  parameter int IDX_MASK0         = 4,
  parameter int IDX_XLAT0         = 8,
  parameter int IDX_CTRL          = 12,
  parameter int IDX_ERRSTAT       = 15,
  parameter int IDX_ERRMASK       = 16,
  parameter int IDX_FLUSH         = 19,
  parameter logic [63:0] CTRL_RST = 64'h0000_0021_0010_0000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [SIZE_W-1:0]         reqSize,
  input  logic [DATA_W-1:0]         reqWdata,
  output logic                      rspValid,
  output logic                      rspErr,
  output logic [DATA_W-1:0]         rspRdata,
  output logic [NUM_WIN*DATA_W-1:0] winBaseFlat,
  output logic [NUM_WIN*DATA_W-1:0] winMaskFlat,
  output logic [NUM_WIN*DATA_W-1:0] winXlatFlat,
  output logic [DATA_W-1:0]         ctrlWord
);

  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  dwrStrobe_t       strobe;
  logic [WIN_W-1:0] winSel;

  dwr_ctrl #(
    .ADDR_W(ADDR_W), .STRIDE_LG(STRIDE_LG), .SIZE_W(SIZE_W), .DATA_W(DATA_W),
    .NUM_WIN(NUM_WIN), .IDX_BASE0(IDX_BASE0), .IDX_MASK0(IDX_MASK0),
    .IDX_XLAT0(IDX_XLAT0), .IDX_CTRL(IDX_CTRL), .IDX_ERRSTAT(IDX_ERRSTAT),
    .IDX_ERRMASK(IDX_ERRMASK), .IDX_FLUSH(IDX_FLUSH)
  ) u_ctrl (
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .reqSize (reqSize),
    .strobe  (strobe),
    .winSel  (winSel)
  );

  dwr_datapath #(
    .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .CTRL_RST(CTRL_RST)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .winSel     (winSel),
    .reqWrite   (reqWrite),
    .reqWdata   (reqWdata),
    .rspValid   (rspValid),
    .rspErr     (rspErr),
    .rspRdata   (rspRdata),
    .winBaseFlat(winBaseFlat),
    .winMaskFlat(winMaskFlat),
    .winXlatFlat(winXlatFlat),
    .ctrlWord   (ctrlWord)
  );

endmodule

// File: rtl/dwr_checker.sv
module dwr_checker #(
  parameter int ADDR_W      = 12,
  parameter int STRIDE_LG   = 6,
  parameter int SIZE_W      = 4,
  parameter int DATA_W      = 64,
  parameter int NUM_WIN     = 4,
  parameter int IDX_ERRSTAT = 15
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      reqValid,
  input logic                      reqWrite,
  input logic [ADDR_W-1:0]         reqAddr,
  input logic [SIZE_W-1:0]         reqSize,
  input logic                      rspValid,
  input logic                      rspErr,
  input logic [DATA_W-1:0]         rspRdata,
  input logic [NUM_WIN*DATA_W-1:0] winBaseFlat,
  input logic [NUM_WIN*DATA_W-1:0] winMaskFlat,
  input logic [NUM_WIN*DATA_W-1:0] winXlatFlat,
  input logic [DATA_W-1:0]         ctrlWord
);

  localparam int WORD_BYTES = DATA_W / 8;

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R9
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspValid && rspRdata == '0));

  // R2
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize != SIZE_W'(WORD_BYTES)) |=> rspErr);

  // R7
  err_keeps_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> ($stable(winBaseFlat) && $stable(winMaskFlat) &&
                $stable(winXlatFlat) && $stable(ctrlWord)));

  // R5
  errstat_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == SIZE_W'(WORD_BYTES) &&
     int'(reqAddr[ADDR_W-1:STRIDE_LG]) == IDX_ERRSTAT)
    |=> (!rspErr && rspRdata == '0));

endmodule

bind dma_window_regs dwr_checker #(
  .ADDR_W(ADDR_W), .STRIDE_LG(STRIDE_LG), .SIZE_W(SIZE_W), .DATA_W(DATA_W),
  .NUM_WIN(NUM_WIN), .IDX_ERRSTAT(IDX_ERRSTAT)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqSize(reqSize), .rspValid(rspValid), .rspErr(rspErr),
  .rspRdata(rspRdata), .winBaseFlat(winBaseFlat), .winMaskFlat(winMaskFlat),
  .winXlatFlat(winXlatFlat), .ctrlWord(ctrlWord)
);

// File: tb/dma_window_regs_tb.sv
module dma_window_regs_tb;

  localparam logic [63:0] CTRL_INIT = 64'h0000_0021_0010_0000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqWrite = 1'b0;
  logic [11:0]  reqAddr = '0;
  logic [3:0]   reqSize = 4'd8;
  logic [63:0]  reqWdata = '0;
  logic         rspValid, rspErr;
  logic [63:0]  rspRdata;
  logic [255:0] winBaseFlat, winMaskFlat, winXlatFlat;
  logic [63:0]  ctrlWord;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [63:0] mdl [64];

  always #10 clk = ~clk;

  dma_window_regs u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .winBaseFlat(winBaseFlat), .winMaskFlat(winMaskFlat),
    .winXlatFlat(winXlatFlat), .ctrlWord(ctrlWord)
  );

  // 0 storing, 1 errstat, 2 flush, 3 errmask, 4 unsupported
  function automatic int kindOf(int idx);
    if (idx <= 12) return 0;
    if (idx == 15) return 1;
    if (idx == 19) return 2;
    if (idx == 16) return 3;
    return 4;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [11:0] addr, logic [3:0] sz, logic [63:0] d,
                        output logic e, output logic [63:0] rd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqSize = sz; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid === 1'b1, "R9 valid", {63'b0, rspValid}, 64'd1);
    e = rspErr;
    rd = rspRdata;
  endtask

  task automatic checkExports(string tag);
    for (int w = 0; w < 4; w++) begin
      check(winBaseFlat[w*64 +: 64] === mdl[w], {"R10 base ", tag}, winBaseFlat[w*64 +: 64], mdl[w]);
      check(winMaskFlat[w*64 +: 64] === mdl[4+w], {"R10 mask ", tag}, winMaskFlat[w*64 +: 64], mdl[4+w]);
      check(winXlatFlat[w*64 +: 64] === mdl[8+w], {"R10 xlat ", tag}, winXlatFlat[w*64 +: 64], mdl[8+w]);
    end
    check(ctrlWord === mdl[12], {"R4 R10 ctrl ", tag}, ctrlWord, mdl[12]);
  endtask

  task automatic readSweep(int lowSeed);
    logic e;
    logic [63:0] rd;
    for (int idx = 0; idx < 64; idx++) begin
      int k;
      logic expE;
      logic [63:0] expD;
      k = kindOf(idx);
      expE = (k == 4);
      expD = (k == 0) ? mdl[idx] : 64'd0;
      access(1'b0, 12'((idx << 6) | ((idx * lowSeed) & 63)), 4'd8, 64'hDEAD, e, rd);
      check(e === expE, "R1 R5 R6 R7 read err", {63'b0, e}, {63'b0, expE});
      check(rd === expD, "R1 R3 R4 R5 R6 R9 read data", rd, expD);
    end
  endtask

  initial begin
    logic e;
    logic [63:0] rd;
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    mdl[12] = CTRL_INIT;
    repeat (3) @(negedge clk);
    check(rspValid === 1'b0, "R9 reset", {63'b0, rspValid}, 64'd0);
    rstN = 1'b1;
    checkExports("reset R3");

    readSweep(7);

    // write sweep, low offset bits varied
    for (int idx = 0; idx < 64; idx++) begin
      int k;
      logic expE;
      logic [63:0] d;
      k = kindOf(idx);
      d = 64'hA5C3_0000_0000_0000 ^ (64'(idx) * 64'h0102_0304_0506_0709);
      expE = (k == 4) || (k == 3);
      access(1'b1, 12'((idx << 6) | ((idx * 13) & 63)), 4'd8, d, e, rd);
      check(e === expE, "R7 R8 R5 R6 write err", {63'b0, e}, {63'b0, expE});
      check(rd === 64'd0, "R9 write data", rd, 64'd0);
      if (k == 0) mdl[idx] = d;
      checkExports("after write R7");
    end

    @(negedge clk);
    check(rspValid === 1'b0, "R9 single pulse", {63'b0, rspValid}, 64'd0);

    readSweep(29);

    // size sweep on the control register
    for (int sz = 0; sz < 16; sz++) begin
      if (sz != 8) begin
        access(1'b1, 12'(12 << 6), 4'(sz), 64'h1111_2222_3333_4444, e, rd);
        check(e === 1'b1, "R2 size write err", {63'b0, e}, 64'd1);
        check(ctrlWord === mdl[12], "R2 size write kept", ctrlWord, mdl[12]);
        access(1'b0, 12'(12 << 6), 4'(sz), 64'd0, e, rd);
        check(e === 1'b1, "R2 size read err", {63'b0, e}, 64'd1);
        check(rd === 64'd0, "R2 R9 size read data", rd, 64'd0);
      end
    end

    // full control write
    access(1'b1, 12'(12 << 6), 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, e, rd);
    mdl[12] = '1;
    check(ctrlWord === mdl[12], "R4 ctrl all ones", ctrlWord, mdl[12]);

    // second reset
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    mdl[12] = CTRL_INIT;
    checkExports("second reset R3");
    readSweep(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule